// File: doc/BRIEF.md
# Security-Banked Floating-Point Control Register File

This block is a memory-mapped register file that holds the floating-point control state of a small processor with two security states. It decodes five word registers on a single-cycle 32-bit register bus. Every access carries a secure or non-secure attribute. The five registers are:

- coprocessor access control
- non-secure access control
- FP context control
- FP context address
- FP default status control

Several registers keep one copy for each security state, and the attribute picks the copy. The context control register is the unusual one. Part of its bits are held per state. The remaining bits are shared and stored only in the secure copy. A non-secure access sees or changes these shared bits only where lock bits in the secure copy, or an external fault-visibility input, allow it.

Two static inputs configure the block. One says whether floating point is present. The other selects the newer architecture, which allows more context control bits. Read data comes back registered, one cycle after the request.

Top module: `fp_ctrl_regs`

## Requirements
- R1: After reset, the secure context control copy is 0xC0000004 (bits 31, 30, 2) and the non-secure copy is 0x80000000 (bit 31). All other registers are zero.
- R2: Read data appears on `rsp_rdata` in the cycle after a read request and is zero in every other cycle. An unmapped offset reads as zero, and a write to it is ignored.
- R3: While `fp_present` is low, every register reads as zero and ignores writes, and the stored contents are kept.
- R4: Coprocessor access control (offset 0xD88) has one copy per security state. A write keeps only bits 23:20.
- R5: Non-secure access control (offset 0xD8C) has a single copy that keeps bits 11:10. A non-secure read returns zero, and a non-secure write is ignored.
- R6: Context address (offset 0xF38) has one copy per state, and a write clears bits 2:0. Default status control (offset 0xF3C) has one copy per state and keeps only mask 0x07C00000.
- R7: In context control (offset 0xF34), a secure read returns the secure copy and a secure write replaces it. Every write clears bits 25:11.
- R8: A non-secure read of context control returns the non-secure copy ORed with the secure copy masked to bits 30, 28 and 8. Bits 4 and 6 are added to that mask when `sfault_ns_vis` is high.
- R9: On a non-secure context control write, bit 30 reaches the secure copy only while secure bit 29 is clear. Bit 28 reaches it only while secure bit 27 is clear.
- R10: On a non-secure context control write, bits 4 and 6 reach the secure copy only when `sfault_ns_vis` is high, and bit 8 always reaches it. The per-state bits (0, 1, 3, 5, 9, 10, 31) go to the non-secure copy.
- R11: With `arch_new` low, a context control write can set only bits 0, 1, 3, 4, 5, 6, 8, 30 and 31 (mask 0xC000017B).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fp_present | input | 1 | Floating point implemented; when low, all registers are read-as-zero and writes are ignored |
| arch_new | input | 1 | Newer architecture mode; widens the context control bits a write can set |
| sfault_ns_vis | input | 1 | Secure fault readiness bits (4, 6) are visible and writable from non-secure |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Access attribute: 1 = secure, 0 = non-secure |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data, valid the cycle after a read |

## Verification
The hardest state to reach from the ports is a secure copy of context control whose lock bits hold shared bits against non-secure writes. The per-state part must also be kept apart from the shared part. The stimulus first clears the secure copy with a secure write. It then lets a non-secure write of all ones spread its bits, and checks both views. Next it sets only the lock bits from the secure side and repeats the non-secure write, to show that the locked bits stay put. The fault-visibility input and the older-architecture mode are each toggled around otherwise identical writes, so that their effect alone shows up at the read port.

// File: rtl/fpreg_pkg.sv
package fpreg_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    // register byte offsets
    localparam logic [ADDR_W-1:0] OFS_CPAC  = 12'hD88;
    localparam logic [ADDR_W-1:0] OFS_NSAC  = 12'hD8C;
    localparam logic [ADDR_W-1:0] OFS_CTX   = 12'hF34;
    localparam logic [ADDR_W-1:0] OFS_CADDR = 12'hF38;
    localparam logic [ADDR_W-1:0] OFS_DSC   = 12'hF3C;

    // keep masks
    localparam logic [DATA_W-1:0] CPAC_KEEP  = 32'h00F0_0000;
    localparam logic [DATA_W-1:0] NSAC_KEEP  = 32'h0000_0C00;
    localparam logic [DATA_W-1:0] CADDR_KEEP = 32'hFFFF_FFF8;
    localparam logic [DATA_W-1:0] DSC_KEEP   = 32'h07C0_0000;

    // context control bit positions
    localparam int CX_HF_RDY   = 4;
    localparam int CX_BF_RDY   = 6;
    localparam int CX_MON_RDY  = 8;
    localparam int CX_CLR_LOCK = 27;
    localparam int CX_CLR_RET  = 28;
    localparam int CX_LZ_LOCK  = 29;
    localparam int CX_LZ_EN    = 30;

    localparam logic [DATA_W-1:0] CX_PER_STATE = 32'h8000_062B;
    localparam logic [DATA_W-1:0] CX_RSV_ZERO  = 32'h03FF_F800;
    localparam logic [DATA_W-1:0] CX_OLD_ARCH  = 32'hC000_017B;
    localparam logic [DATA_W-1:0] CX_NS_SEE    = 32'h5000_0100;
    localparam logic [DATA_W-1:0] CX_NS_FAULT  = 32'h0000_0050;
    localparam logic [DATA_W-1:0] CX_RST_SEC   = 32'hC000_0004;
    localparam logic [DATA_W-1:0] CX_RST_NSEC  = 32'h8000_0000;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CPAC,
        SEL_NSAC,
        SEL_CTX,
        SEL_CADDR,
        SEL_DSC
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] sec;
        logic [DATA_W-1:0] nsec;
    } ctx_pair_t;

    function automatic reg_sel_e map_offset(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_CPAC:  return SEL_CPAC;
            OFS_NSAC:  return SEL_NSAC;
            OFS_CTX:   return SEL_CTX;
            OFS_CADDR: return SEL_CADDR;
            OFS_DSC:   return SEL_DSC;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/fpreg_decode.sv
module fpreg_decode
    import fpreg_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          valid,
    input  logic          write,
    input  logic          fp_on,
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel,
    output logic          wr_go,
    output logic          rd_go
);
    always_comb begin
        sel   = fp_on ? map_offset(addr) : SEL_NONE;
        wr_go = valid && write && fp_on;
        rd_go = valid && !write;
    end
endmodule

// File: rtl/fpreg_banked.sv
module fpreg_banked
    import fpreg_pkg::*;
#(
    parameter int              DW          = DATA_W,
    parameter logic [DW-1:0]   KEEP        = '1,
    parameter bit              SECURE_ONLY = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic          secure,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int NBANK = SECURE_ONLY ? 1 : 2;

    logic [DW-1:0] store [NBANK];

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            logic hit;
            if (SECURE_ONLY) begin : g_sonly
                assign hit = secure;
            end else begin : g_pair
                assign hit = (secure == b[0]);
            end
            always_ff @(posedge clk) begin
                if (rst)
                    store[b] <= '0;
                else if (wr && hit)
                    store[b] <= wdata & KEEP;
            end
        end

        if (SECURE_ONLY) begin : g_rd_sonly
            assign rdata = secure ? store[0] : '0;
        end else begin : g_rd_pair
            assign rdata = store[secure];
        end
    endgenerate
endmodule

// File: rtl/fpreg_ctx.sv
module fpreg_ctx
    import fpreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              secure,
    input  logic              arch_new,
    input  logic              sf_vis,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    ctx_pair_t st, nxt;
    logic [DATA_W-1:0] v, s;

    always_comb begin
        v = wdata & ~CX_RSV_ZERO;
        if (!arch_new)
            v = v & CX_OLD_ARCH;
        nxt = st;
        s   = st.sec;
        if (wr) begin
            if (secure) begin
                nxt.sec = v;
            end else begin
                if (!st.sec[CX_LZ_LOCK])
                    s[CX_LZ_EN] = v[CX_LZ_EN];
                if (!st.sec[CX_CLR_LOCK])
                    s[CX_CLR_RET] = v[CX_CLR_RET];
                if (sf_vis) begin
                    s[CX_HF_RDY] = v[CX_HF_RDY];
                    s[CX_BF_RDY] = v[CX_BF_RDY];
                end
                s[CX_MON_RDY] = v[CX_MON_RDY];
                nxt.sec  = s;
                nxt.nsec = v & CX_PER_STATE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.sec  <= CX_RST_SEC;
            st.nsec <= CX_RST_NSEC;
        end else begin
            st <= nxt;
        end
    end

    always_comb begin
        if (secure)
            rdata = st.sec;
        else
            rdata = (st.sec & (CX_NS_SEE | (sf_vis ? CX_NS_FAULT : '0))) | st.nsec;
    end
endmodule

// File: rtl/fp_ctrl_regs.sv
module fp_ctrl_regs
    import fpreg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fp_present,
    input  logic          arch_new,
    input  logic          sfault_ns_vis,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_secure,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rsp_rdata
);
    reg_sel_e      sel;
    logic          wr_go, rd_go;
    logic [DW-1:0] rd_cpac, rd_nsac, rd_caddr, rd_dsc, rd_ctx, rd_mux;

    fpreg_decode #(.AW(AW)) u_dec (
        .valid (req_valid),
        .write (req_write),
        .fp_on (fp_present),
        .addr  (req_addr),
        .sel   (sel),
        .wr_go (wr_go),
        .rd_go (rd_go)
    );

    fpreg_banked #(.DW(DW), .KEEP(CPAC_KEEP), .SECURE_ONLY(1'b0)) u_cpac (
        .clk(clk), .rst(rst), .wr(wr_go && sel == SEL_CPAC),
        .secure(req_secure), .wdata(req_wdata), .rdata(rd_cpac)
    );

    fpreg_banked #(.DW(DW), .KEEP(NSAC_KEEP), .SECURE_ONLY(1'b1)) u_nsac (
        .clk(clk), .rst(rst), .wr(wr_go && sel == SEL_NSAC),
        .secure(req_secure), .wdata(req_wdata), .rdata(rd_nsac)
    );

    fpreg_banked #(.DW(DW), .KEEP(CADDR_KEEP), .SECURE_ONLY(1'b0)) u_caddr (
        .clk(clk), .rst(rst), .wr(wr_go && sel == SEL_CADDR),
        .secure(req_secure), .wdata(req_wdata), .rdata(rd_caddr)
    );

    fpreg_banked #(.DW(DW), .KEEP(DSC_KEEP), .SECURE_ONLY(1'b0)) u_dsc (
        .clk(clk), .rst(rst), .wr(wr_go && sel == SEL_DSC),
        .secure(req_secure), .wdata(req_wdata), .rdata(rd_dsc)
    );

    fpreg_ctx u_ctx (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_go && sel == SEL_CTX),
        .secure   (req_secure),
        .arch_new (arch_new),
        .sf_vis   (sfault_ns_vis),
        .wdata    (req_wdata),
        .rdata    (rd_ctx)
    );

    always_comb begin
        case (sel)
            SEL_CPAC:  rd_mux = rd_cpac;
            SEL_NSAC:  rd_mux = rd_nsac;
            SEL_CTX:   rd_mux = rd_ctx;
            SEL_CADDR: rd_mux = rd_caddr;
            SEL_DSC:   rd_mux = rd_dsc;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rsp_rdata <= '0;
        else
            rsp_rdata <= rd_go ? rd_mux : '0;
    end
endmodule

// File: rtl/fp_ctrl_regs_chk.sv
module fp_ctrl_regs_chk
    import fpreg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fp_present,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_secure,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] rsp_rdata
);
    logic rd;
    assign rd = req_valid && !req_write;

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd |=> rsp_rdata == '0);

    // R3
    absent_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && !fp_present) |=> rsp_rdata == '0);

    // R5
    nsac_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && !req_secure && req_addr == OFS_NSAC) |=> rsp_rdata == '0);

    // R4
    cpac_field_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && req_addr == OFS_CPAC) |=> (rsp_rdata & ~CPAC_KEEP) == '0);

    // R6
    caddr_align_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && req_addr == OFS_CADDR) |=> rsp_rdata[2:0] == 3'b000);

    // R7
    ctx_rsv_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && req_addr == OFS_CTX) |=> rsp_rdata[25:11] == '0);
endmodule

bind fp_ctrl_regs fp_ctrl_regs_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .fp_present (fp_present),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_secure (req_secure),
    .req_addr   (req_addr),
    .rsp_rdata  (rsp_rdata)
);

// File: tb/fp_ctrl_regs_test.sv
`timescale 1ns/1ps
module fp_ctrl_regs_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fp_present = 1'b1;
    logic        arch_new = 1'b1;
    logic        sfault_ns_vis = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_secure = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;

    localparam logic [11:0] A_CPAC = 12'hD88, A_NSAC = 12'hD8C, A_CTX = 12'hF34,
                            A_CADDR = 12'hF38, A_DSC = 12'hF3C;
    localparam bit SEC = 1'b1, NSEC = 1'b0;

    always #2.5 clk = ~clk;

    fp_ctrl_regs uut (
        .clk(clk), .rst(rst), .fp_present(fp_present), .arch_new(arch_new),
        .sfault_ns_vis(sfault_ns_vis), .req_valid(req_valid), .req_write(req_write),
        .req_secure(req_secure), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit s);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_secure = s; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input bit s, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_secure = s; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input bit s,
                          input logic [31:0] exp);
        logic [31:0] d;
        rd(a, s, d);
        check(req, d, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 ctx secure", A_CTX, SEC, 32'hC000_0004);
        rd_chk("R1 ctx nonsecure", A_CTX, NSEC, 32'hC000_0000);
        rd_chk("R1 cpac", A_CPAC, SEC, 32'h0);
        rd_chk("R1 caddr", A_CADDR, NSEC, 32'h0);
    endtask

    task automatic t_bus;
        rd_chk("R2 read data", A_CTX, SEC, 32'hC000_0004);
        @(negedge clk);
        check("R2 idle zero", rsp_rdata, 32'h0);
        rd_chk("R2 unmapped read", 12'hD80, SEC, 32'h0);
        wr(12'hD90, 32'hFFFF_FFFF, SEC);
        rd_chk("R2 unmapped write ignored", 12'hD90, SEC, 32'h0);
    endtask

    task automatic t_cpac;
        wr(A_CPAC, 32'hFFFF_FFFF, SEC);
        rd_chk("R4 secure keep 23:20", A_CPAC, SEC, 32'h00F0_0000);
        rd_chk("R4 nonsecure separate", A_CPAC, NSEC, 32'h0);
        wr(A_CPAC, 32'h00A0_0000, NSEC);
        rd_chk("R4 nonsecure copy", A_CPAC, NSEC, 32'h00A0_0000);
        rd_chk("R4 secure unchanged", A_CPAC, SEC, 32'h00F0_0000);
    endtask

    task automatic t_nsac;
        wr(A_NSAC, 32'hFFFF_FFFF, SEC);
        rd_chk("R5 secure keep 11:10", A_NSAC, SEC, 32'h0000_0C00);
        rd_chk("R5 nonsecure reads zero", A_NSAC, NSEC, 32'h0);
        wr(A_NSAC, 32'h0, NSEC);
        rd_chk("R5 nonsecure write ignored", A_NSAC, SEC, 32'h0000_0C00);
    endtask

    task automatic t_addr_dsc;
        wr(A_CADDR, 32'hFFFF_FFFF, SEC);
        wr(A_CADDR, 32'h1234_5677, NSEC);
        rd_chk("R6 caddr secure", A_CADDR, SEC, 32'hFFFF_FFF8);
        rd_chk("R6 caddr nonsecure", A_CADDR, NSEC, 32'h1234_5670);
        wr(A_DSC, 32'hFFFF_FFFF, SEC);
        rd_chk("R6 dsc secure", A_DSC, SEC, 32'h07C0_0000);
        rd_chk("R6 dsc nonsecure", A_DSC, NSEC, 32'h0);
    endtask

    task automatic t_ctx_sec;
        sfault_ns_vis = 1'b0;
        wr(A_CTX, 32'hFFFF_FFFF, SEC);
        rd_chk("R7 secure write clears 25:11", A_CTX, SEC, 32'hFC00_07FF);
        rd_chk("R8 nonsecure view", A_CTX, NSEC, 32'hD000_0100);
        sfault_ns_vis = 1'b1;
        rd_chk("R8 nonsecure view with fault bits", A_CTX, NSEC, 32'hD000_0150);
        sfault_ns_vis = 1'b0;
    endtask

    task automatic t_ctx_locks;
        wr(A_CTX, 32'h0, SEC);
        wr(A_CTX, 32'hFFFF_FFFF, NSEC);
        rd_chk("R10 shared bits into secure copy", A_CTX, SEC, 32'h5000_0100);
        rd_chk("R10 per-state bits into nonsecure copy", A_CTX, NSEC, 32'hD000_072B);
        wr(A_CTX, 32'h2800_0000, SEC);
        wr(A_CTX, 32'h5000_0000, NSEC);
        rd_chk("R9 locked bits held", A_CTX, SEC, 32'h2800_0000);
    endtask

    task automatic t_ctx_fault;
        wr(A_CTX, 32'h0, SEC);
        sfault_ns_vis = 1'b0;
        wr(A_CTX, 32'h0000_0050, NSEC);
        rd_chk("R10 fault bits blocked", A_CTX, SEC, 32'h0);
        sfault_ns_vis = 1'b1;
        wr(A_CTX, 32'h0000_0050, NSEC);
        rd_chk("R10 fault bits pass", A_CTX, SEC, 32'h0000_0050);
        wr(A_CTX, 32'h0000_0100, NSEC);
        rd_chk("R10 monitor bit always", A_CTX, SEC, 32'h0000_0100);
        sfault_ns_vis = 1'b0;
    endtask

    task automatic t_arch;
        arch_new = 1'b0;
        wr(A_CTX, 32'hFFFF_FFFF, SEC);
        rd_chk("R11 secure old arch mask", A_CTX, SEC, 32'hC000_017B);
        sfault_ns_vis = 1'b1;
        wr(A_CTX, 32'hFFFF_FFFF, NSEC);
        rd_chk("R11 nonsecure old arch view", A_CTX, NSEC, 32'hC000_017B);
        sfault_ns_vis = 1'b0;
        rd_chk("R11 nonsecure copy old arch", A_CTX, NSEC, 32'hC000_012B);
        arch_new = 1'b1;
    endtask

    task automatic t_absent;
        fp_present = 1'b0;
        rd_chk("R3 cpac reads zero", A_CPAC, SEC, 32'h0);
        rd_chk("R3 ctx reads zero", A_CTX, SEC, 32'h0);
        wr(A_CPAC, 32'h0, SEC);
        fp_present = 1'b1;
        rd_chk("R3 write ignored", A_CPAC, SEC, 32'h00F0_0000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bus();
        t_cpac();
        t_nsac();
        t_addr_dsc();
        t_ctx_sec();
        t_ctx_locks();
        t_ctx_fault();
        t_arch();
        t_absent();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule